// File: doc/BRIEF.md
# Global status latch and interrupt aggregator

This block gathers a handful of chip-wide conditions and presents them to software in two read-only views. The live view shows, as of the last clock, whether every port that opted into global performance updating has finished its update, and whether any PLL has lost lock. The latched view holds five sticky event bits. Two of them capture rising edges of the live bits. One is set by a periodic tick from a prescaler that stands in for a one-second timer. Two record activity on a reference clock input and on an 8 kHz reference input.

Software clears a latched bit by writing 1 to it. Each latched bit has its own interrupt enable. The enabled bits are ORed into a summary status bit, and a second, summary-level enable gates that bit onto an active-low interrupt pin. Both enable levels come in as inputs, because the registers that hold them sit in another bank.

Top module: `gsi_irq_hub`

## Requirements
- R1: Live register bit 0 reads 1 exactly when at least one port has its global-update mode input high and every such port has its update-status input high. Ports with mode low are ignored, and the bit reads 0 when no port has mode high. The value reflects the inputs sampled at the previous clock edge.
- R2: Live register bit 1 reads 1 when any PLL lock input was low at the previous clock edge. Live register bits 15:2 read 0, and a read at any offset other than 0x14 or 0x16 returns 0.
- R3: Latched bit 0 is set when live bit 0 goes from 0 to 1, and latched bit 1 is set when live bit 1 goes from 0 to 1. Each is visible two clock edges after the input change. A live bit that stays high does not set its latched bit again.
- R4: Latched bit 2 is set at every TICK_CYCLES-th clock edge after reset is released.
- R5: Latched bit 3 is set three clock edges after any edge, rising or falling, on the reference clock input.
- R6: Latched bit 4 is set three clock edges after any edge on the 8 kHz reference input, but only when the monitoring enable input is high at that third edge. Edges seen while the enable is low leave the bit unchanged.
- R7: Writing to offset 0x16 clears each latched bit whose write-data bit is 1. A set condition in the same cycle wins over the clear. Bits written as 0 and writes to offset 0x14 change nothing. Latched bits 15:5 read 0.
- R8: The summary status output is high in the same cycle in which any latched bit is high together with its per-bit enable (enable bit i goes with latched bit i). It falls once every enabled latched bit has been cleared or disabled.
- R9: The interrupt output is low exactly when the summary status is high and the summary enable input is high. It is high otherwise.
- R10: While reset is asserted, and on the first cycle after it is released, both registers read 0, the summary is low and the interrupt output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset for read and write |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data (1 clears a latched bit) |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| port_upd_done | input | NPORT | Per-port update-complete flags |
| port_gmode | input | NPORT | Per-port opt-in to global update |
| pll_locked | input | NPLL | Per-PLL lock indication |
| pll_ref_in | input | 1 | PLL reference clock, monitored for activity |
| ref8k_in | input | 1 | 8 kHz reference, monitored for activity |
| ref8k_mon_en | input | 1 | Enables activity capture for the 8 kHz reference |
| lat_ie | input | 5 | Per-latched-bit interrupt enables |
| sum_ie | input | 1 | Summary interrupt enable |
| sum_status | output | 1 | Summary global status |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Each result has a fixed delay. The live bits appear one edge after their inputs change. The edge-captured latched bits appear two edges after the input change, the activity bits three edges after it, and the tick bit at every TICK_CYCLES-th edge. Summary, interrupt and read data follow the latched state and the enable inputs within the same cycle. The bench drives all inputs at the falling edge. A behavioural model advances at every rising edge with those same delays written as sample histories and counters. Every output is compared with the model 1 ns after each falling edge, so each result is checked in the cycle in which it is due.

// File: rtl/gsi_pkg.sv
package gsi_pkg;
   localparam int unsigned BIT_UPD  = 0;
   localparam int unsigned BIT_LOL  = 1;
   localparam int unsigned BIT_SEC  = 2;
   localparam int unsigned BIT_REF  = 3;
   localparam int unsigned BIT_8K   = 4;
   localparam int unsigned NUM_LAT  = 5;
   localparam int unsigned NUM_LIVE = 2;

   typedef logic [NUM_LAT-1:0]  lat_vec_t;
   typedef logic [NUM_LIVE-1:0] live_vec_t;
endpackage

// File: rtl/gsi_live_eval.sv
module gsi_live_eval
   import gsi_pkg::*;
#(
   parameter int unsigned NPORT = 4,
   parameter int unsigned NPLL  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPORT-1:0] port_upd_done,
   input  logic [NPORT-1:0] port_gmode,
   input  logic [NPLL-1:0]  pll_locked,
   output live_vec_t        live_q,
   output live_vec_t        rise
);
   if (NPORT < 1) begin : g_bad_nport
      $error("gsi_live_eval: NPORT must be at least 1");
   end
   if (NPLL < 1) begin : g_bad_npll
      $error("gsi_live_eval: NPLL must be at least 1");
   end

   logic [NPORT-1:0] port_ok;
   live_vec_t        live_d;
   live_vec_t        prev_q;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign port_ok[p] = port_upd_done[p] | ~port_gmode[p];
   end

   assign live_d[BIT_UPD] = (&port_ok) & (|port_gmode);
   assign live_d[BIT_LOL] = ~(&pll_locked);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
         prev_q <= '0;
      end else begin
         live_q <= live_d;
         prev_q <= live_q;
      end
   end

   assign rise = live_q & ~prev_q;

   p_upd_none_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (port_gmode == '0) |=> !live_q[BIT_UPD]);

   p_lol_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (&pll_locked) |=> !live_q[BIT_LOL]);
endmodule

// File: rtl/gsi_edge_act.sv
module gsi_edge_act #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic act
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gsi_edge_act: STAGES must be at least 2");
   end

   logic [STAGES:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[STAGES-1:0], din};
   end

   assign act = sync_q[STAGES-1] ^ sync_q[STAGES];
endmodule

// File: rtl/gsi_tick_gen.sv
module gsi_tick_gen #(
   parameter int unsigned TICK_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (TICK_CYCLES < 1) begin : g_bad_tick
      $error("gsi_tick_gen: TICK_CYCLES must be at least 1");
   end

   if (TICK_CYCLES == 1) begin : g_every
      assign tick = 1'b1;
   end else begin : g_count
      localparam int unsigned CW = $clog2(TICK_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cnt_q <= '0;
         else if (cnt_q == LAST) cnt_q <= '0;
         else                   cnt_q <= cnt_q + 1'b1;
      end

      assign tick = (cnt_q == LAST);

      p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= LAST);

      p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

// File: rtl/gsi_latch_bank.sv
module gsi_latch_bank
   import gsi_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  lat_vec_t set_vec,
   input  lat_vec_t clr_vec,
   input  lat_vec_t bit_ie,
   output lat_vec_t lat_q,
   output logic     sum
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= '0;
      else        lat_q <= (lat_q & ~clr_vec) | set_vec;
   end

   assign sum = |(lat_q & bit_ie);

   p_w1c_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_vec & ~set_vec)) |=> ((lat_q & $past(clr_vec & ~set_vec)) == '0));

   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((lat_q & $past(set_vec)) == $past(set_vec)));

   p_sum_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sum |-> (bit_ie != '0));
endmodule

// File: rtl/gsi_irq_hub.sv
module gsi_irq_hub
   import gsi_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned NPORT       = 4,
   parameter int unsigned NPLL        = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TICK_CYCLES = 1000,
   parameter logic [ADDR_W-1:0] LIVE_OFS = ADDR_W'('h14),
   parameter logic [ADDR_W-1:0] LAT_OFS  = ADDR_W'('h16)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPORT-1:0]  port_upd_done,
   input  logic [NPORT-1:0]  port_gmode,
   input  logic [NPLL-1:0]   pll_locked,
   input  logic              pll_ref_in,
   input  logic              ref8k_in,
   input  logic              ref8k_mon_en,
   input  logic [4:0]        lat_ie,
   input  logic              sum_ie,
   output logic              sum_status,
   output logic              irq_n
);
   if (DATA_W < NUM_LAT) begin : g_bad_width
      $error("gsi_irq_hub: DATA_W too narrow for the latched bits");
   end
   if (LIVE_OFS == LAT_OFS) begin : g_bad_ofs
      $error("gsi_irq_hub: register offsets must differ");
   end

   live_vec_t live_q;
   live_vec_t rise;
   logic      act_ref;
   logic      act_8k;
   logic      tick;
   lat_vec_t  set_vec;
   lat_vec_t  clr_vec;
   lat_vec_t  lat_q;
   logic      lat_hit;
   logic      unused_wdata;

   gsi_live_eval #(.NPORT(NPORT), .NPLL(NPLL)) i_live (
      .clk(clk), .rst_n(rst_n),
      .port_upd_done(port_upd_done), .port_gmode(port_gmode),
      .pll_locked(pll_locked), .live_q(live_q), .rise(rise)
   );

   gsi_edge_act #(.STAGES(SYNC_STAGES)) i_act_ref (
      .clk(clk), .rst_n(rst_n), .din(pll_ref_in), .act(act_ref)
   );

   gsi_edge_act #(.STAGES(SYNC_STAGES)) i_act_8k (
      .clk(clk), .rst_n(rst_n), .din(ref8k_in), .act(act_8k)
   );

   gsi_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) i_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[BIT_UPD] = rise[BIT_UPD];
      set_vec[BIT_LOL] = rise[BIT_LOL];
      set_vec[BIT_SEC] = tick;
      set_vec[BIT_REF] = act_ref;
      set_vec[BIT_8K]  = act_8k & ref8k_mon_en;
   end

   assign lat_hit      = bus_wr && (bus_addr == LAT_OFS);
   assign clr_vec      = lat_hit ? bus_wdata[NUM_LAT-1:0] : '0;
   assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_LAT];

   gsi_latch_bank i_bank (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
      .bit_ie(lat_ie), .lat_q(lat_q), .sum(sum_status)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == LIVE_OFS)     bus_rdata[NUM_LIVE-1:0] = live_q;
      else if (bus_addr == LAT_OFS) bus_rdata[NUM_LAT-1:0]  = lat_q;
   end

   assign irq_n = ~(sum_status & sum_ie);

   p_rise_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(live_q[BIT_LOL]) |=> lat_q[BIT_LOL]);

   p_8k_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!lat_q[BIT_8K] && !ref8k_mon_en) |=> !lat_q[BIT_8K]);

   p_irq_needs_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (lat_q != '0));

   p_irq_needs_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (sum_ie && sum_status));
endmodule

// File: tb/test_gsi_irq_hub.sv
module test_gsi_irq_hub;
   localparam int NPORT = 4;
   localparam int NPLL  = 3;
   localparam int TICK  = 37;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h14;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [NPORT-1:0] port_upd_done = '0;
   logic [NPORT-1:0] port_gmode = '0;
   logic [NPLL-1:0]  pll_locked = '1;
   logic        pll_ref_in = 1'b0;
   logic        ref8k_in = 1'b0;
   logic        ref8k_mon_en = 1'b0;
   logic [4:0]  lat_ie = '0;
   logic        sum_ie = 1'b0;
   logic        sum_status;
   logic        irq_n;

   int    n_run = 0;
   int    n_fail = 0;
   bit    finished = 1'b0;
   string cur_req = "R10";

   always #5 clk = ~clk;

   gsi_irq_hub #(.NPORT(NPORT), .NPLL(NPLL), .TICK_CYCLES(TICK)) i_gsi_irq_hub (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .port_upd_done(port_upd_done), .port_gmode(port_gmode),
      .pll_locked(pll_locked), .pll_ref_in(pll_ref_in), .ref8k_in(ref8k_in),
      .ref8k_mon_en(ref8k_mon_en), .lat_ie(lat_ie), .sum_ie(sum_ie),
      .sum_status(sum_status), .irq_n(irq_n)
   );

   // Behavioural reference model, advanced at every rising edge.
   bit [1:0] m_live;
   bit [1:0] m_live_old;
   bit [4:0] m_lat;
   int       m_cnt;
   bit       hist_ref[$];
   bit       hist_8k[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_live = '0; m_live_old = '0; m_lat = '0; m_cnt = 0;
         hist_ref = '{1'b0, 1'b0, 1'b0};
         hist_8k  = '{1'b0, 1'b0, 1'b0};
      end else begin
         bit [4:0] setv;
         bit [4:0] clrv;
         bit any_mode, all_done, lol;
         any_mode = 0; all_done = 1; lol = 0;
         for (int i = 0; i < NPORT; i++)
            if (port_gmode[i]) begin
               any_mode = 1;
               if (!port_upd_done[i]) all_done = 0;
            end
         for (int j = 0; j < NPLL; j++)
            if (!pll_locked[j]) lol = 1;
         setv = '0;
         setv[0] = m_live[0] && !m_live_old[0];   // R3
         setv[1] = m_live[1] && !m_live_old[1];   // R3
         m_cnt++;
         if (m_cnt == TICK) begin setv[2] = 1; m_cnt = 0; end  // R4
         setv[3] = hist_ref[1] != hist_ref[2];                  // R5
         setv[4] = (hist_8k[1] != hist_8k[2]) && ref8k_mon_en;  // R6
         hist_ref.push_front(pll_ref_in); void'(hist_ref.pop_back());
         hist_8k.push_front(ref8k_in);    void'(hist_8k.pop_back());
         clrv = (bus_wr && bus_addr == 8'h16) ? bus_wdata[4:0] : '0; // R7
         m_lat = (m_lat & ~clrv) | setv;
         m_live_old = m_live;
         m_live = {lol, any_mode && all_done};                 // R1 R2
      end
   end

   // Output comparison, 1 ns after every falling edge.
   always @(negedge clk) begin
      if (!finished) begin
         logic [15:0] e_rd;
         logic        e_sum;
         logic        e_irq;
         #1;
         e_rd = '0;
         if (bus_addr == 8'h14)      e_rd[1:0] = m_live;
         else if (bus_addr == 8'h16) e_rd[4:0] = m_lat;
         e_sum = |(m_lat & lat_ie);            // R8
         e_irq = !(e_sum && sum_ie);           // R9
         n_run++;
         if (bus_rdata !== e_rd) begin
            n_fail++;
            $display("FAIL %s rdata@%h got %h exp %h", cur_req, bus_addr, bus_rdata, e_rd);
         end
         n_run++;
         if (sum_status !== e_sum) begin
            n_fail++;
            $display("FAIL %s sum_status got %b exp %b", cur_req, sum_status, e_sum);
         end
         n_run++;
         if (irq_n !== e_irq) begin
            n_fail++;
            $display("FAIL %s irq_n got %b exp %b", cur_req, irq_n, e_irq);
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_lat(input logic [15:0] d);
      @(negedge clk);
      bus_addr = 8'h16; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   initial begin
      logic [15:0] lfsr;
      // R10: reset state and first cycle after release
      cur_req = "R10";
      bus_addr = 8'h16;
      cyc(4);
      rst_n = 1'b1;
      cyc(1);
      bus_addr = 8'h14;
      cyc(1);

      // R1: global update flag over opted-in ports only
      cur_req = "R1";
      port_upd_done = 4'b1111; port_gmode = 4'b0000; cyc(3);
      port_gmode = 4'b0101; port_upd_done = 4'b0101; cyc(3);
      port_upd_done = 4'b0100; cyc(3);
      port_gmode = 4'b1111; port_upd_done = 4'b1111; cyc(3);
      port_upd_done = 4'b1110; cyc(2);

      // R2: loss of lock and unmapped reads
      cur_req = "R2";
      pll_locked = 3'b110; cyc(3);
      pll_locked = 3'b011; cyc(2);
      bus_addr = 8'h00; cyc(2);
      bus_addr = 8'h15; cyc(2);
      pll_locked = 3'b111;

      // R3: edge capture, reading the latched view
      cur_req = "R3";
      bus_addr = 8'h16; cyc(3);
      wr_lat(16'h0003);
      port_upd_done = 4'b1111; cyc(6);
      pll_locked = 3'b101; cyc(6);
      wr_lat(16'h0003); cyc(4);   // live still high: no re-set
      pll_locked = 3'b111; cyc(3);

      // R7: write-one-to-clear, zero bits and wrong offset
      cur_req = "R7";
      wr_lat(16'h0000); cyc(1);
      @(negedge clk); bus_addr = 8'h14; bus_wr = 1'b1; bus_wdata = 16'hFFFF;
      @(negedge clk); bus_wr = 1'b0; bus_addr = 8'h16; cyc(2);
      wr_lat(16'hFFE0); cyc(1);
      wr_lat(16'h001F); cyc(2);
      // set wins: clear lands on the edge where activity sets bit 3
      @(negedge clk); pll_ref_in = ~pll_ref_in;
      @(negedge clk);
      @(negedge clk); bus_wr = 1'b1; bus_wdata = 16'h0008;
      @(negedge clk); bus_wr = 1'b0; bus_wdata = '0; cyc(3);

      // R4: periodic tick over several periods
      cur_req = "R4";
      wr_lat(16'h001F);
      cyc(2 * TICK + 5);
      wr_lat(16'h0004);
      cyc(TICK + 3);

      // R5: reference clock activity, both edge directions
      cur_req = "R5";
      wr_lat(16'h001F);
      pll_ref_in = 1'b1; cyc(5);
      wr_lat(16'h0008); cyc(2);
      pll_ref_in = 1'b0; cyc(5);

      // R6: 8 kHz activity gated by monitoring enable
      cur_req = "R6";
      wr_lat(16'h001F);
      ref8k_mon_en = 1'b0;
      ref8k_in = 1'b1; cyc(6);
      ref8k_in = 1'b0; cyc(6);
      ref8k_mon_en = 1'b1;
      ref8k_in = 1'b1; cyc(6);
      wr_lat(16'h0010);
      ref8k_in = 1'b0; cyc(1);
      ref8k_mon_en = 1'b0; cyc(4);   // enable low at the capture edge

      // R8: per-bit enables into the summary
      cur_req = "R8";
      wr_lat(16'h001F);
      lat_ie = 5'b01000; cyc(2);
      pll_ref_in = ~pll_ref_in; cyc(5);
      lat_ie = 5'b00111; cyc(2);
      lat_ie = 5'b01000; cyc(2);
      wr_lat(16'h0008); cyc(2);

      // R9: summary enable onto the pin
      cur_req = "R9";
      pll_ref_in = ~pll_ref_in; cyc(5);
      sum_ie = 1'b1; cyc(3);
      lat_ie = 5'b00000; cyc(2);
      lat_ie = 5'b11111; cyc(2);
      wr_lat(16'h001F); cyc(3);
      sum_ie = 1'b0; cyc(2);

      // R8: mixed pseudo-random stimulus
      cur_req = "R8";
      lfsr = 16'hACE1;
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         port_gmode    = lfsr[3:0];
         port_upd_done = lfsr[7:4] | lfsr[11:8];
         pll_locked    = (lfsr[2:0] == 3'b000) ? 3'b010 : 3'b111;
         if (lfsr[9]) pll_ref_in = ~pll_ref_in;
         if (lfsr[12] && lfsr[1]) ref8k_in = ~ref8k_in;
         ref8k_mon_en = lfsr[14];
         lat_ie = lfsr[15:11];
         sum_ie = lfsr[5];
         bus_addr = lfsr[8] ? 8'h16 : (lfsr[6] ? 8'h14 : 8'h20);
         bus_wr = (lfsr[10:9] == 2'b11);
         bus_wdata = {lfsr[0], lfsr[15:1]};
      end
      @(negedge clk); bus_wr = 1'b0;
      cyc(3);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         finished = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired during %s", cur_req);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule